// File: doc/BRIEF.md
# Memory-Mapped 16x16 Multiply-Accumulate Unit

This peripheral sits on a simple word-wide register bus and multiplies two 16-bit operands. The product can either replace the result or be added to a running 32-bit accumulator. Software first writes operand A to one of four neighbouring addresses. The address it picks sets the operating mode: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Software then writes operand B, and that write starts the operation in the recorded mode. From the next clock cycle the low and high result words and an extension word can be read. The extension word gives the sign of a signed result, or the carry of an unsigned accumulate.

The mode is held in a four-state register. The states are MODE_UMUL (value 0), MODE_SMUL (1), MODE_UMAC (2) and MODE_SMAC (3). There is one kind of transition: a write to the operand-A address at byte offset 2*k moves the machine to the state with value k, from any state. Every other bus cycle leaves the state where it is, and that includes operand-B writes. So a single operand-A write can serve several operand-B triggers. Reads are combinational from the address, and all addresses are byte addresses relative to a base.

Top module: `mac16_periph`

## Requirements
- R1: After reset, every readable location reads 0x0000, and the mode is unsigned multiply (state 0).
- R2: A write to offset 0x0, 0x2, 0x4 or 0x6 latches operand A and sets the mode to that offset divided by two. It leaves the result, accumulator and extension words unchanged.
- R3: A write to offset 0x8 latches operand B and runs the operation in the recorded mode. Its outcome is readable in the next cycle. Operand A and the mode are kept, so further operand-B writes repeat the operation with new B values.
- R4: Unsigned multiply (mode 0) sets the result to the zero-extended 32-bit product, clears the accumulator and sets the extension word to 0x0000.
- R5: Signed multiply (mode 1) treats both operands as two's complement and sets the result to the 32-bit two's-complement product. It clears the accumulator. The extension word is 0xFFFF when the product is negative, otherwise 0x0000.
- R6: Unsigned accumulate (mode 2) adds the unsigned product to the accumulator modulo 2^32, and the result words show the new accumulator. The extension word is 0x0001 if that addition carried out of bit 31, otherwise 0x0000.
- R7: Signed accumulate (mode 3) adds the signed product to the accumulator, and the result words show the new accumulator. The extension word is 0xFFFF when bit 31 of the new accumulator is set, otherwise 0x0000.
- R8: Read map: offset 0xA gives result bits 15:0, 0xC gives bits 31:16, and 0xE gives the extension word. Offsets 0x0 to 0x6 all read operand A, and 0x8 reads operand B. Odd addresses and addresses outside the 16-byte window read 0x0000.
- R9: Writes to offsets 0xA, 0xC and 0xE, to odd addresses, and to addresses outside the window have no effect on any register or on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |

## Verification
The bench uses the default parameters: a 16-bit address, base 0x0130 and 16-bit data. With these values the bench can reach addresses just below and just above the window (0x012E, 0x0140) and odd addresses inside it, which exercises the edges of the decode. The 16-bit data width lets corner operands such as 0xFFFF and 0x8000 reach both the 32-bit carry-out of an unsigned accumulate and the sign flips of a signed accumulate within a few operations.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

    // Operating mode; the value equals (operand-A byte offset / 2).
    typedef enum logic [1:0] {
        MODE_UMUL = 2'd0,
        MODE_SMUL = 2'd1,
        MODE_UMAC = 2'd2,
        MODE_SMAC = 2'd3
    } mac_mode_e;

    // Decoded target of a bus access.
    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_OPA,
        SLOT_OPB,
        SLOT_RLO,
        SLOT_RHI,
        SLOT_EXT
    } mac_slot_e;

    // Word index (byte offset / 2) of each location inside the window.
    localparam logic [2:0] WIDX_OPB = 3'd4;
    localparam logic [2:0] WIDX_RLO = 3'd5;
    localparam logic [2:0] WIDX_RHI = 3'd6;
    localparam logic [2:0] WIDX_EXT = 3'd7;

    localparam int WINDOW_BYTES = 16;

endpackage

// File: rtl/mac16_decode.sv
module mac16_decode
    import mac16_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130
) (
    input  logic [ADDR_W-1:0] addr,
    output mac_slot_e         slot,
    output logic [1:0]        opa_mode
);

    logic [ADDR_W-1:0] ofs;
    logic              in_window;

    assign ofs       = addr - BASE_ADDR;
    assign in_window = (ofs < ADDR_W'(WINDOW_BYTES)) && !ofs[0];
    assign opa_mode  = ofs[2:1];

    always_comb begin
        slot = SLOT_NONE;
        if (in_window) begin
            unique case (ofs[3:1])
                WIDX_OPB: slot = SLOT_OPB;
                WIDX_RLO: slot = SLOT_RLO;
                WIDX_RHI: slot = SLOT_RHI;
                WIDX_EXT: slot = SLOT_EXT;
                default:  slot = SLOT_OPA;
            endcase
        end
    end

endmodule

// File: rtl/mac16_arith.sv
module mac16_arith
    import mac16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mac_mode_e             mode,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [2*DATA_W-1:0]   acc,
    output logic [2*DATA_W-1:0]   res_nxt,
    output logic [2*DATA_W-1:0]   acc_nxt,
    output logic [DATA_W-1:0]     ext_nxt
);

    localparam int RES_W = 2 * DATA_W;

    logic [RES_W-1:0] za, zb, sa, sb;
    logic [RES_W-1:0] uprod, sprod, prod;
    logic [RES_W:0]   sum;

    assign za    = {{DATA_W{1'b0}}, opa};
    assign zb    = {{DATA_W{1'b0}}, opb};
    assign sa    = {{DATA_W{opa[DATA_W-1]}}, opa};
    assign sb    = {{DATA_W{opb[DATA_W-1]}}, opb};
    assign uprod = za * zb;
    assign sprod = sa * sb;
    assign prod  = (mode == MODE_SMAC) ? sprod : uprod;
    assign sum   = {1'b0, acc} + {1'b0, prod};

    always_comb begin
        unique case (mode)
            MODE_UMUL: begin
                res_nxt = uprod;
                acc_nxt = '0;
                ext_nxt = '0;
            end
            MODE_SMUL: begin
                res_nxt = sprod;
                acc_nxt = '0;
                ext_nxt = {DATA_W{sprod[RES_W-1]}};
            end
            MODE_UMAC: begin
                res_nxt = sum[RES_W-1:0];
                acc_nxt = sum[RES_W-1:0];
                ext_nxt = {{(DATA_W-1){1'b0}}, sum[RES_W]};
            end
            default: begin
                res_nxt = sum[RES_W-1:0];
                acc_nxt = sum[RES_W-1:0];
                ext_nxt = {DATA_W{sum[RES_W-1]}};
            end
        endcase
    end

endmodule

// File: rtl/mac16_periph.sv
module mac16_periph
    import mac16_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130,
    parameter int                DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int RES_W = 2 * DATA_W;

    mac_slot_e        slot;
    logic [1:0]       opa_mode;
    mac_mode_e        mode_q, mode_d;
    logic [DATA_W-1:0] op1_q, op2_q, ext_q, ext_nxt;
    logic [RES_W-1:0] acc_q, res_q, acc_nxt, res_nxt;
    logic             wr_opa, wr_opb;

    mac16_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr     (bus_addr),
        .slot     (slot),
        .opa_mode (opa_mode)
    );

    mac16_arith #(
        .DATA_W (DATA_W)
    ) u_arith (
        .mode    (mode_q),
        .opa     (op1_q),
        .opb     (bus_wdata),
        .acc     (acc_q),
        .res_nxt (res_nxt),
        .acc_nxt (acc_nxt),
        .ext_nxt (ext_nxt)
    );

    assign wr_opa = bus_we && (slot == SLOT_OPA);
    assign wr_opb = bus_we && (slot == SLOT_OPB);

    // Mode transitions: only an operand-A write moves the machine.
    always_comb begin
        mode_d = mode_q;
        if (wr_opa) begin
            mode_d = mac_mode_e'(opa_mode);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_UMUL;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Operand and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op1_q <= '0;
            op2_q <= '0;
            acc_q <= '0;
            res_q <= '0;
            ext_q <= '0;
        end else begin
            if (wr_opa) begin
                op1_q <= bus_wdata;
            end
            if (wr_opb) begin
                op2_q <= bus_wdata;
                acc_q <= acc_nxt;
                res_q <= res_nxt;
                ext_q <= ext_nxt;
            end
        end
    end

    // Output process: read data.
    always_comb begin
        unique case (slot)
            SLOT_OPA: bus_rdata = op1_q;
            SLOT_OPB: bus_rdata = op2_q;
            SLOT_RLO: bus_rdata = res_q[DATA_W-1:0];
            SLOT_RHI: bus_rdata = res_q[RES_W-1:DATA_W];
            SLOT_EXT: bus_rdata = ext_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mac16_checker.sv
module mac16_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130,
    parameter int                DATA_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [1:0]          mode_q,
    input logic [DATA_W-1:0]   op1_q,
    input logic [DATA_W-1:0]   ext_q,
    input logic [2*DATA_W-1:0] acc_q,
    input logic [2*DATA_W-1:0] res_q
);

    localparam int RES_W = 2 * DATA_W;

    logic [ADDR_W-1:0] ofs;
    logic              inside_win, wr_a, wr_b, wr_ro, wr_bad;

    assign ofs        = bus_addr - BASE_ADDR;
    assign inside_win = (ofs < ADDR_W'(16)) && !ofs[0];
    assign wr_a       = bus_we && inside_win && !ofs[3];
    assign wr_b       = bus_we && (ofs == ADDR_W'(8));
    assign wr_ro      = bus_we && inside_win && ofs[3] && (ofs[2:1] != 2'b00);
    assign wr_bad     = bus_we && !inside_win;

    AST_OPA_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> $stable(res_q) && $stable(acc_q) && $stable(ext_q)); // R2

    AST_OPA_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> mode_q == $past(ofs[2:1])); // R2

    AST_TRIGGER_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !wr_a) |=> $stable(mode_q) && $stable(op1_q)); // R3

    AST_PLAIN_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !mode_q[1]) |=> acc_q == '0); // R4

    AST_UMUL_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && mode_q == 2'd0) |=> ext_q == '0); // R4

    AST_SMUL_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && mode_q == 2'd1) |=> ext_q == {DATA_W{res_q[RES_W-1]}}); // R5

    AST_MAC_RESULT_IS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && mode_q[1]) |=> res_q == acc_q); // R6

    AST_UMAC_EXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && mode_q == 2'd2) |=> $countones(ext_q) <= 1 && ext_q[DATA_W-1:1] == '0); // R6

    AST_SMAC_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && mode_q == 2'd3) |=> ext_q == {DATA_W{acc_q[RES_W-1]}}); // R7

    AST_DEAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ro || wr_bad) |=> $stable(res_q) && $stable(acc_q) && $stable(ext_q)
                              && $stable(op1_q) && $stable(mode_q)); // R9

endmodule

bind mac16_periph mac16_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .DATA_W    (DATA_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .mode_q   (mode_q),
    .op1_q    (op1_q),
    .ext_q    (ext_q),
    .acc_q    (acc_q),
    .res_q    (res_q)
);

// File: tb/mac16_periph_bench.sv
module mac16_periph_bench;

    localparam logic [15:0] BASE = 16'h0130;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    logic [31:0] acc_m = '0;
    logic [31:0] res_m = '0;
    logic [15:0] ext_m = '0;
    logic [15:0] opa_m = '0;
    int          mode_m = 0;

    mac16_periph u_mac16_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    initial begin
        #4_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic check(input string tag, input string what, input logic [15:0] got,
                         input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_read(input string tag, input logic [15:0] a, input logic [15:0] exp);
        logic [15:0] d;
        bus_read(a, d);
        check(tag, $sformatf("read @%h", a), d, exp);
    endtask

    task automatic expect_results(input string tag);
        expect_read(tag, BASE + 16'hA, res_m[15:0]);
        expect_read(tag, BASE + 16'hC, res_m[31:16]);
        expect_read(tag, BASE + 16'hE, ext_m);
    endtask

    // Operand-B trigger using the model's recorded mode and operand A.
    task automatic fire(input logic [15:0] b, input string tag);
        logic [63:0] pu, ps;
        logic [32:0] sum;
        pu = {48'd0, opa_m} * {48'd0, b};
        ps = {{48{opa_m[15]}}, opa_m} * {{48{b[15]}}, b};
        case (mode_m)
            0: begin res_m = pu[31:0]; acc_m = '0; ext_m = '0; end
            1: begin res_m = ps[31:0]; acc_m = '0; ext_m = ps[31] ? 16'hFFFF : 16'h0000; end
            2: begin
                sum   = {1'b0, acc_m} + {1'b0, pu[31:0]};
                acc_m = sum[31:0];
                res_m = acc_m;
                ext_m = {15'd0, sum[32]};
            end
            default: begin
                acc_m = acc_m + ps[31:0];
                res_m = acc_m;
                ext_m = acc_m[31] ? 16'hFFFF : 16'h0000;
            end
        endcase
        bus_write(BASE + 16'h8, b);
        expect_results(tag);
    endtask

    task automatic set_opa(input int mode, input logic [15:0] a);
        mode_m = mode;
        opa_m  = a;
        bus_write(BASE + 16'(2 * mode), a);
    endtask

    task automatic do_op(input int mode, input logic [15:0] a, input logic [15:0] b,
                         input string tag);
        set_opa(mode, a);
        fire(b, tag);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 8; k++) begin
            expect_read("R1", BASE + 16'(2 * k), 16'h0000);
        end
    endtask

    task automatic t_umul;
        do_op(0, 16'hFFFF, 16'hFFFF, "R4");
        do_op(0, 16'h1234, 16'h0000, "R4");
        do_op(0, 16'h8000, 16'h0003, "R4");
    endtask

    task automatic t_smul;
        do_op(1, 16'hFFFF, 16'h0002, "R5");
        do_op(1, 16'hFFFD, 16'hFFFC, "R5");
        do_op(1, 16'h8000, 16'h8000, "R5");
        do_op(1, 16'h7FFF, 16'h8000, "R5");
    endtask

    task automatic t_umac;
        do_op(0, 16'h0000, 16'h0000, "R4");
        do_op(2, 16'hFFFF, 16'hFFFF, "R6");
        fire(16'hFFFF, "R6");
        fire(16'hFFFF, "R6");
        do_op(2, 16'h0001, 16'h0001, "R6");
    endtask

    task automatic t_smac;
        do_op(1, 16'h0000, 16'h0000, "R5");
        do_op(3, 16'hFFFF, 16'h0001, "R7");
        do_op(3, 16'h0002, 16'h0001, "R7");
        do_op(3, 16'h8000, 16'h7FFF, "R7");
    endtask

    task automatic t_repeat;
        do_op(0, 16'h0000, 16'h0000, "R3");
        set_opa(2, 16'h0003);
        fire(16'h0005, "R3");
        fire(16'h0005, "R3");
        expect_read("R3", BASE + 16'h4, 16'h0003);
    endtask

    task automatic t_opa_only;
        do_op(0, 16'h0010, 16'h0010, "R2");
        set_opa(3, 16'h0007);
        expect_results("R2");
        expect_read("R2", BASE + 16'h6, 16'h0007);
        fire(16'hFFFF, "R2");
    endtask

    task automatic t_plain_clears;
        do_op(2, 16'h0100, 16'h0100, "R6");
        do_op(0, 16'h0003, 16'h0004, "R4");
        do_op(2, 16'h0001, 16'h0001, "R4");
    endtask

    task automatic t_readmap;
        set_opa(2, 16'hBEEF);
        for (int k = 0; k < 4; k++) begin
            expect_read("R8", BASE + 16'(2 * k), 16'hBEEF);
        end
        fire(16'h5A5A, "R8");
        expect_read("R8", BASE + 16'h8, 16'h5A5A);
        expect_read("R8", BASE - 16'h2, 16'h0000);
        expect_read("R8", BASE + 16'h10, 16'h0000);
        expect_read("R8", BASE + 16'h1, 16'h0000);
        expect_read("R8", BASE + 16'hB, 16'h0000);
    endtask

    task automatic t_ignored;
        do_op(1, 16'h1111, 16'hF00F, "R9");
        bus_write(BASE + 16'hA, 16'hFFFF);
        bus_write(BASE + 16'hC, 16'hFFFF);
        bus_write(BASE + 16'hE, 16'h0000);
        bus_write(BASE + 16'h1, 16'hAAAA);
        bus_write(BASE + 16'h5, 16'hAAAA);
        bus_write(BASE + 16'h10, 16'hAAAA);
        bus_write(BASE - 16'h2, 16'hAAAA);
        expect_results("R9");
        expect_read("R9", BASE + 16'h2, 16'h1111);
        fire(16'h0002, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_umul();
        t_smul();
        t_umac();
        t_smac();
        t_repeat();
        t_opa_only();
        t_plain_clears();
        t_readmap();
        t_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule